// File: doc/BRIEF.md
# Synchronous Serial Character Receiver

This block takes serial characters from one data line that is timed by an externally supplied baud-rate clock. The baud clock and the data line are both brought into the system clock domain through the same synchronizer depth, and the data line is sampled exactly once for each rising baud edge. No oversampling is used. A low sample while the receiver is idle marks a start bit. The data bits follow, least significant first, then an optional parity bit and one stop bit.

A finished character goes into a holding register and raises a ready flag. The host clears the ready flag with a one-cycle read strobe. If a new character completes while the previous one is still unread, it overwrites the holding register and sets a sticky overrun flag. The overrun, parity error and framing error flags clear only on a reset-status strobe. Character length and parity mode are static configuration inputs.

Top module: `sync_char_rx`

## Requirements
- R1: The data line is sampled once per rising edge of `baud_clk_i`. Holding the data line low while the baud clock does not toggle starts no reception.
- R2: In idle, a sampled low bit starts a character. A sampled high bit keeps the receiver idle.
- R3: `char_len_i` selects 5 + code data bits (codes 0..4 give 5..9 bits; codes above 4 give 9). Bits arrive LSB first, and unused upper bits of `rx_data_o` read as zero.
- R4: The frame is start, data bits, parity bit when enabled, then one stop bit. `parity_i` codes: 0 none, 1 even, 2 odd, 3 forced 0, 4 forced 1, 5..7 none.
- R5: When a character completes, `rx_data_o` holds it and `rx_rdy_o` is set.
- R6: A character that completes while `rx_rdy_o` is already set overwrites `rx_data_o` and sets `ovr_err_o`.
- R7: A one-cycle `rd_i` pulse clears `rx_rdy_o`.
- R8: `rst_sta_i` clears `ovr_err_o`, `par_err_o` and `frm_err_o`. `rd_i` leaves all three unchanged.
- R9: `par_err_o` is set when the received parity bit differs from the bit the selected mode expects (even: total ones even; odd: total ones odd).
- R10: `frm_err_o` is set when the sampled stop bit is low.
- R11: After the stop bit, a start bit on the very next rising baud edge is accepted, so frames may follow back to back.
- R12: If `rd_i` falls in the same system cycle as a character completion, `rx_rdy_o` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| baud_clk_i | input | 1 | External baud-rate clock |
| rxd_i | input | 1 | Serial data line |
| char_len_i | input | 3 | Data bit count code |
| parity_i | input | 3 | Parity mode code |
| rd_i | input | 1 | Holding register read strobe |
| rst_sta_i | input | 1 | Reset-status strobe for error flags |
| rx_data_o | output | 9 | Received character |
| rx_rdy_o | output | 1 | Receiver ready flag |
| ovr_err_o | output | 1 | Sticky overrun flag |
| par_err_o | output | 1 | Sticky parity error flag |
| frm_err_o | output | 1 | Sticky framing error flag |

## Verification
Two events can land in the same system cycle: the host's read strobe, which clears the ready flag, and a character completion, which sets it and may also set overrun. The bench drives the baud clock itself. From the rising edge of the stop bit it counts the synchronizer stages and the two register stages, then places a single read pulse on exactly the cycle in which the completion reaches the status flags. It does this with an unread character already held. The result is judged at the ports: ready must stay set, the holding register must show the second character, and overrun must be set. A later lone read must clear ready while leaving overrun set.

// File: rtl/sync_char_rx_pkg.sv
package sync_char_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_PAR, ST_STOP} rx_state_e;

  localparam logic [2:0] PAR_NONE = 3'd0;
  localparam logic [2:0] PAR_EVEN = 3'd1;
  localparam logic [2:0] PAR_ODD  = 3'd2;
  localparam logic [2:0] PAR_ZERO = 3'd3;
  localparam logic [2:0] PAR_ONE  = 3'd4;
endpackage

// File: rtl/sync_char_rx_edge.sv
module sync_char_rx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic baud_clk_i,
  input  logic rxd_i,
  output logic tick_o,
  output logic bit_o
);
  logic [SYNC_STAGES-1:0] baud_sq, rxd_sq;
  logic baud_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      baud_sq     <= '0;
      rxd_sq      <= '1;
      baud_prev_q <= 1'b0;
    end else begin
      baud_sq     <= {baud_sq[SYNC_STAGES-2:0], baud_clk_i};
      rxd_sq      <= {rxd_sq[SYNC_STAGES-2:0], rxd_i};
      baud_prev_q <= baud_sq[SYNC_STAGES-1];
    end
  end

  assign tick_o = baud_sq[SYNC_STAGES-1] & ~baud_prev_q;
  assign bit_o  = rxd_sq[SYNC_STAGES-1];

  // R1
  single_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sync_char_rx_frame.sv
module sync_char_rx_frame
  import sync_char_rx_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int LEN_W   = 3,
  parameter int MIN_LEN = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bit_i,
  input  logic [LEN_W-1:0]  char_len_i,
  input  logic [2:0]        parity_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_bad_o,
  output logic              frm_bad_o
);
  localparam int CNT_W = $clog2(DATA_W);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q, last_idx;
  logic [DATA_W-1:0] data_q;
  logic              par_bit_q, par_en, exp_par;

  always_comb begin
    if (char_len_i > LEN_W'(DATA_W - MIN_LEN)) last_idx = CNT_W'(DATA_W - 1);
    else last_idx = CNT_W'(char_len_i) + CNT_W'(MIN_LEN - 1);
  end

  always_comb begin
    par_en  = 1'b1;
    exp_par = 1'b0;
    case (parity_i)
      PAR_EVEN: exp_par = ^data_q;
      PAR_ODD:  exp_par = ~^data_q;
      PAR_ZERO: exp_par = 1'b0;
      PAR_ONE:  exp_par = 1'b1;
      default:  par_en  = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      data_q    <= '0;
      par_bit_q <= 1'b0;
      done_o    <= 1'b0;
      par_bad_o <= 1'b0;
      frm_bad_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        case (state_q)
          ST_IDLE: if (!bit_i) begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
            data_q  <= '0;
          end
          ST_DATA: begin
            data_q[cnt_q] <= bit_i;
            cnt_q         <= cnt_q + 1'b1;
            if (cnt_q == last_idx) state_q <= par_en ? ST_PAR : ST_STOP;
          end
          ST_PAR: begin
            par_bit_q <= bit_i;
            state_q   <= ST_STOP;
          end
          default: begin
            done_o    <= 1'b1;
            par_bad_o <= par_en && (par_bit_q != exp_par);
            frm_bad_o <= !bit_i;
            state_q   <= ST_IDLE;
          end
        endcase
      end
    end
  end

  assign data_o = data_q;

  // R2
  start_detect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && tick_i && !bit_i) |=> (state_q == ST_DATA));
  // R11
  stop_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && tick_i) |=> (state_q == ST_IDLE && done_o));
  // R10
  stop_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && tick_i && !bit_i) |=> frm_bad_o);
endmodule

// File: rtl/sync_char_rx_status.sv
module sync_char_rx_status #(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_bad_i,
  input  logic              frm_bad_i,
  input  logic              rd_i,
  input  logic              rst_sta_i,
  output logic [DATA_W-1:0] hold_o,
  output logic              rdy_o,
  output logic              ovr_o,
  output logic              par_err_o,
  output logic              frm_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o    <= '0;
      rdy_o     <= 1'b0;
      ovr_o     <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
    end else begin
      if (done_i) begin
        hold_o <= data_i;
        rdy_o  <= 1'b1;               // set beats read clear
      end else if (rd_i) begin
        rdy_o  <= 1'b0;
      end
      if (done_i && rdy_o)              ovr_o     <= 1'b1;
      else if (rst_sta_i)               ovr_o     <= 1'b0;
      if (done_i && par_bad_i)          par_err_o <= 1'b1;
      else if (rst_sta_i)               par_err_o <= 1'b0;
      if (done_i && frm_bad_i)          frm_err_o <= 1'b1;
      else if (rst_sta_i)               frm_err_o <= 1'b0;
    end
  end

  // R5
  ready_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (rdy_o && hold_o == $past(data_i)));
  // R6
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && rdy_o) |=> ovr_o);
  // R7
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> !rdy_o);
  // R8
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !rst_sta_i) |=> ovr_o);
endmodule

// File: rtl/sync_char_rx.sv
module sync_char_rx #(
  parameter int DATA_W      = 9,
  parameter int LEN_W       = 3,
  parameter int MIN_LEN     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_clk_i,
  input  logic              rxd_i,
  input  logic [LEN_W-1:0]  char_len_i,
  input  logic [2:0]        parity_i,
  input  logic              rd_i,
  input  logic              rst_sta_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_rdy_o,
  output logic              ovr_err_o,
  output logic              par_err_o,
  output logic              frm_err_o
);
  logic tick, sbit, done, par_bad, frm_bad;
  logic [DATA_W-1:0] data;

  sync_char_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .baud_clk_i, .rxd_i, .tick_o(tick), .bit_o(sbit)
  );

  sync_char_rx_frame #(.DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_frame (
    .clk_i, .rst_ni, .tick_i(tick), .bit_i(sbit), .char_len_i, .parity_i,
    .done_o(done), .data_o(data), .par_bad_o(par_bad), .frm_bad_o(frm_bad)
  );

  sync_char_rx_status #(.DATA_W(DATA_W)) u_status (
    .clk_i, .rst_ni, .done_i(done), .data_i(data), .par_bad_i(par_bad),
    .frm_bad_i(frm_bad), .rd_i, .rst_sta_i, .hold_o(rx_data_o), .rdy_o(rx_rdy_o),
    .ovr_o(ovr_err_o), .par_err_o, .frm_err_o
  );
endmodule

// File: tb/sync_char_rx_test.sv
module sync_char_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0;
  logic baud = 0, rxd = 1;
  logic [2:0] cfg_len = 3'd3, cfg_par = 3'd0;
  logic rd_mon = 0, rd_drv = 0, sta_mon = 0, sta_drv = 0;
  logic [8:0] data_o;
  logic rdy_o, ovr_o, perr_o, ferr_o;
  logic mon_en = 0;
  logic done_flag = 0;
  int n_cmp = 0, n_bad = 0;
  logic [10:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_char_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .baud_clk_i(baud), .rxd_i(rxd),
    .char_len_i(cfg_len), .parity_i(cfg_par), .rd_i(rd_mon | rd_drv),
    .rst_sta_i(sta_mon | sta_drv), .rx_data_o(data_o), .rx_rdy_o(rdy_o),
    .ovr_err_o(ovr_o), .par_err_o(perr_o), .frm_err_o(ferr_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input bit collide);
    @(negedge clk); rxd = b; baud = 0;
    repeat (HALF - 1) @(negedge clk);
    @(negedge clk); baud = 1;
    if (collide) begin
      repeat (3) @(negedge clk);
      rd_drv = 1;
      @(negedge clk); rd_drv = 0;
      repeat (HALF - 5) @(negedge clk);
    end else begin
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [8:0] d, input bit bad_par, input bit bad_stop,
                            input bit collide, input bit push, input bit idle_after);
    int nbits;
    logic [8:0] m;
    logic p;
    bit pen;
    nbits = (cfg_len > 3'd4) ? 9 : 5 + int'(cfg_len);
    m = d & ((9'h1 << nbits) - 9'h1);
    pen = 1'b1;
    case (cfg_par)
      3'd1: p = ^m;
      3'd2: p = ~^m;
      3'd3: p = 1'b0;
      3'd4: p = 1'b1;
      default: begin p = 1'b0; pen = 1'b0; end
    endcase
    if (push) exp_q.push_back({bad_stop, pen & bad_par, m});
    send_bit(1'b0, 0);
    for (int i = 0; i < nbits; i++) send_bit(m[i], 0);
    if (pen) send_bit(p ^ bad_par, 0);
    send_bit(!bad_stop, collide);
    if (idle_after) send_bit(1'b1, 0);
  endtask

  // monitor: compare each produced character against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && rdy_o) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R5: actual unexpected character %0h expected none", data_o);
        end else begin
          logic [10:0] e;
          e = exp_q.pop_front();
          check("R5/R3/R4 data", {7'd0, data_o}, {7'd0, e[8:0]});
          check("R9 parity flag", {15'd0, perr_o}, {15'd0, e[9]});
          check("R10 framing flag", {15'd0, ferr_o}, {15'd0, e[10]});
        end
        rd_mon = 1; sta_mon = 1;
        @(negedge clk); rd_mon = 0; sta_mon = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("reset rdy", {15'd0, rdy_o}, 16'd0);
    check("reset ovr", {15'd0, ovr_o}, 16'd0);
    check("reset flags", {14'd0, perr_o, ferr_o}, 16'd0);
    check("reset data", {7'd0, data_o}, 16'd0);

    // R1: low data without baud edges starts nothing
    rxd = 0; repeat (60) @(negedge clk); rxd = 1;
    send_bit(1'b1, 0); send_bit(1'b1, 0);
    check("R1 no edge no frame", {15'd0, rdy_o}, 16'd0);
    // R2: idle high bits keep receiver idle
    check("R2 idle stays idle", {15'd0, rdy_o}, 16'd0);

    mon_en = 1;
    // R3 lengths, R4 parity modes
    cfg_len = 3'd3; cfg_par = 3'd0; send_frame(9'h0A5, 0, 0, 0, 1, 1);
    cfg_len = 3'd0; cfg_par = 3'd1; send_frame(9'h1FF, 0, 0, 0, 1, 1); // R3 upper bits zero
    cfg_len = 3'd4; cfg_par = 3'd2; send_frame(9'h155, 0, 0, 0, 1, 1);
    cfg_len = 3'd7; cfg_par = 3'd3; send_frame(9'h1A3, 0, 0, 0, 1, 1); // R3 code>4 -> 9
    cfg_len = 3'd2; cfg_par = 3'd4; send_frame(9'h03C, 0, 0, 0, 1, 1);
    cfg_len = 3'd1; cfg_par = 3'd6; send_frame(9'h02B, 0, 0, 0, 1, 1); // R4 code 6 none
    // R9 parity errors
    cfg_len = 3'd3; cfg_par = 3'd1; send_frame(9'h081, 1, 0, 0, 1, 1);
    cfg_par = 3'd2; send_frame(9'h07E, 1, 0, 0, 1, 1);
    // R10 framing error
    cfg_par = 3'd0; send_frame(9'h066, 0, 1, 0, 1, 1);
    // R11 back to back frames
    send_frame(9'h011, 0, 0, 0, 1, 0);
    send_frame(9'h0EE, 0, 0, 0, 1, 0);
    send_frame(9'h0C3, 0, 0, 0, 1, 1);
    repeat (10) @(negedge clk);
    check("R11 scoreboard drained", 16'(exp_q.size()), 16'd0);

    // R6/R12: overrun with read in the completion cycle
    mon_en = 0;
    @(negedge clk);
    send_frame(9'h05A, 0, 0, 0, 0, 0);
    check("R5 first char ready", {15'd0, rdy_o}, 16'd1);
    send_frame(9'h0B4, 0, 0, 1, 0, 0);
    check("R12 ready kept on collision", {15'd0, rdy_o}, 16'd1);
    check("R6 data overwritten", {7'd0, data_o}, 16'h0B4);
    check("R6 overrun set", {15'd0, ovr_o}, 16'd1);
    // R7/R8: read clears ready, not overrun
    @(negedge clk); rd_drv = 1; @(negedge clk); rd_drv = 0; @(negedge clk);
    check("R7 read clears ready", {15'd0, rdy_o}, 16'd0);
    check("R8 read keeps overrun", {15'd0, ovr_o}, 16'd1);
    sta_drv = 1; @(negedge clk); sta_drv = 0; @(negedge clk);
    check("R8 reset-status clears overrun", {15'd0, ovr_o}, 16'd0);

    // R8: error flags cleared only by reset-status
    cfg_par = 3'd1;
    send_frame(9'h013, 1, 1, 0, 0, 1);
    @(negedge clk); rd_drv = 1; @(negedge clk); rd_drv = 0; @(negedge clk);
    check("R8 read keeps error flags", {14'd0, perr_o, ferr_o}, 16'd3);
    sta_drv = 1; @(negedge clk); sta_drv = 0; @(negedge clk);
    check("R8 reset-status clears error flags", {14'd0, perr_o, ferr_o}, 16'd0);

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule